// File: doc/BRIEF.md
# Dual-Rate Dot-Clock Enable Generator

This block derives a pixel-rate enable from a fast master clock. In normal operation it emits one single-cycle enable pulse every four master clocks. While the horizontal sync line (active low) is asserted, the dot period stretches to five master clocks. This reproduces a video timing in which the pixel clock slows down through the sync portion of each line.

The sync line is treated as an input that the block only observes. The change of rate therefore trails the sync edges. After sync is seen asserted, a fixed number of dots still run at the fast rate before the slow rate begins. After sync is seen released, a fixed number of dots still run at the slow rate, which stands in for the slow pull-up rise of an open-drain sync line. Both lags are counted in dots, and the rate only ever changes at the end of a dot.

A mode input turns the variable rate off, which leaves a plain divide-by-four. The enable drives the pixel pipeline of a video generator. The reported ratio tells downstream logic how many master clocks the current dot occupies.

Top module: `dotclk_gen`

## Requirements
- R1: While reset is high, the divide counter is cleared, `dotEn` is 0 and `divRatio` reads 4. The first `dotEn` pulse appears on the third rising edge after reset is released, because the cleared count is the first cycle of the first dot.
- R2: With `varEn` = 1 and `hsyncN` = 1 at every dot end, consecutive `dotEn` pulses are exactly 4 master clocks apart and `divRatio` reads 4.
- R3: `dotEn` is high for exactly one master clock per dot. Within a dot it rises only once the number of cycles given by `divRatio` has elapsed.
- R4: Inputs are sampled in the cycle in which `dotEn` is high, and they govern the next dot. When `hsyncN` = 0 is sampled coming from the fast state, the next ENTRY_LAG dots (default 7) still last 4 clocks.
- R5: Once the entry lag has elapsed, every dot that starts with `hsyncN` = 0 sampled lasts 5 clocks and `divRatio` reads 5.
- R6: When `hsyncN` = 1 is sampled after the slow rate has begun, the next EXIT_LAG dots (default 3) last 5 clocks. The dots after those return to 4 clocks.
- R7: `divRatio` changes value only in the cycle that follows a `dotEn` pulse.
- R8: With `varEn` = 0 sampled at a dot end, the next dot lasts 4 clocks whatever `hsyncN` is. This includes the case where the slow rate was active, with no exit lag applied.
- R9: With the default lags, a sync held low for 64 dots spans exactly 313 master clocks, made up of 7 dots of 4 followed by 57 dots of 5.
- R10: If `hsyncN` = 1 is sampled before the entry lag has elapsed, the rate stays at 4 and no exit lag follows.
- R11: If `hsyncN` = 0 is sampled again during the exit lag, the slow rate continues at once without a new entry lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| hsyncN | input | 1 | Observed horizontal sync level, 0 = sync asserted |
| varEn | input | 1 | 1 enables the sync-dependent slow rate |
| dotEn | output | 1 | One-cycle dot enable pulse |
| divRatio | output | 3 | Master clocks in the current dot (4 or 5) |

## Verification
The properties assume that `hsyncN` and `varEn` are synchronous to the master clock. They do not need the inputs to stay stable within a dot, because the block looks at them only in the cycle of a `dotEn` pulse. The stimulus changes both inputs one nanosecond after the falling clock edge that shows a pulse, so each new value is sampled at exactly one dot end. A scoreboard therefore knows, for every dot, the period that the requirements predict. Scenarios cover long, short and re-asserted sync, as well as the mode being turned off mid-sync.

// File: rtl/dotclk_pkg.sv
package dotclk_pkg;

  // Strobes from control to datapath, acted upon only at a dot end.
  typedef struct packed {
    logic goSlow;
    logic goFast;
  } rateCmd_t;

  typedef enum logic [1:0] {
    PH_FAST  = 2'd0,
    PH_ENTRY = 2'd1,
    PH_SLOW  = 2'd2,
    PH_EXIT  = 2'd3
  } ratePhase_t;

endpackage

// File: rtl/dotclk_div.sv
module dotclk_div
  import dotclk_pkg::*;
#(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 5,
  parameter int RATIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  rateCmd_t           cmd,
  output logic               tick,
  output logic [RATIO_W-1:0] divRatio
);

  localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] divCnt;
  logic             slowSel;
  logic [CNT_W-1:0] lastIdx;

  assign lastIdx  = slowSel ? SLOW_LAST : FAST_LAST;
  assign tick     = (divCnt == lastIdx);
  assign divRatio = slowSel ? RATIO_W'(SLOW_DIV) : RATIO_W'(FAST_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt  <= '0;
      slowSel <= 1'b0;
    end else if (tick) begin
      divCnt <= '0;
      if (cmd.goSlow)      slowSel <= 1'b1;
      else if (cmd.goFast) slowSel <= 1'b0;
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dotclk_ctrl.sv
module dotclk_ctrl
  import dotclk_pkg::*;
#(
  parameter int ENTRY_LAG = 7,
  parameter int EXIT_LAG  = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     syncLow,
  input  logic     varEn,
  output rateCmd_t cmd
);

  localparam int LAG_MAX = (ENTRY_LAG > EXIT_LAG) ? ENTRY_LAG : EXIT_LAG;
  localparam int LAG_W   = (LAG_MAX < 1) ? 1 : $clog2(LAG_MAX + 1);
  localparam logic [LAG_W-1:0] ENTRY_END = LAG_W'(ENTRY_LAG);
  localparam logic [LAG_W-1:0] EXIT_END  = LAG_W'(EXIT_LAG);
  localparam logic [LAG_W-1:0] LAG_ONE   = LAG_W'(1);

  ratePhase_t       phase, phaseNext;
  logic [LAG_W-1:0] lagCnt, lagNext;

  always_comb begin
    phaseNext = phase;
    lagNext   = lagCnt;
    cmd       = '0;
    if (tick) begin
      if (!varEn) begin
        phaseNext  = PH_FAST;
        lagNext    = '0;
        cmd.goFast = 1'b1;
      end else begin
        unique case (phase)
          PH_FAST: begin
            if (syncLow) begin
              if (ENTRY_LAG == 0) begin
                phaseNext  = PH_SLOW;
                cmd.goSlow = 1'b1;
              end else begin
                phaseNext = PH_ENTRY;
                lagNext   = LAG_ONE;
              end
            end
          end
          PH_ENTRY: begin
            if (!syncLow) begin
              phaseNext = PH_FAST;
              lagNext   = '0;
            end else if (lagCnt >= ENTRY_END) begin
              phaseNext  = PH_SLOW;
              lagNext    = '0;
              cmd.goSlow = 1'b1;
            end else begin
              lagNext = lagCnt + LAG_ONE;
            end
          end
          PH_SLOW: begin
            if (!syncLow) begin
              if (EXIT_LAG == 0) begin
                phaseNext  = PH_FAST;
                cmd.goFast = 1'b1;
              end else begin
                phaseNext = PH_EXIT;
                lagNext   = LAG_ONE;
              end
            end
          end
          PH_EXIT: begin
            if (syncLow) begin
              phaseNext = PH_SLOW;
              lagNext   = '0;
            end else if (lagCnt >= EXIT_END) begin
              phaseNext  = PH_FAST;
              lagNext    = '0;
              cmd.goFast = 1'b1;
            end else begin
              lagNext = lagCnt + LAG_ONE;
            end
          end
          default: begin
            phaseNext  = PH_FAST;
            cmd.goFast = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_FAST;
      lagCnt <= '0;
    end else begin
      phase  <= phaseNext;
      lagCnt <= lagNext;
    end
  end

endmodule

// File: rtl/dotclk_gen.sv
module dotclk_gen
  import dotclk_pkg::*;
#(
  parameter int FAST_DIV  = 4,
  parameter int SLOW_DIV  = 5,
  parameter int ENTRY_LAG = 7,
  parameter int EXIT_LAG  = 3,
  localparam int RATIO_W  = $clog2(SLOW_DIV + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hsyncN,
  input  logic               varEn,
  output logic               dotEn,
  output logic [RATIO_W-1:0] divRatio
);

  rateCmd_t rateCmd;
  logic     tick;

  dotclk_ctrl #(
    .ENTRY_LAG(ENTRY_LAG),
    .EXIT_LAG (EXIT_LAG)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .syncLow(~hsyncN),
    .varEn  (varEn),
    .cmd    (rateCmd)
  );

  dotclk_div #(
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV),
    .RATIO_W (RATIO_W)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .cmd     (rateCmd),
    .tick    (tick),
    .divRatio(divRatio)
  );

  assign dotEn = tick;

endmodule

// File: rtl/dotclk_chk.sv
module dotclk_chk #(
  parameter int FAST_DIV = 4,
  parameter int SLOW_DIV = 5,
  parameter int RATIO_W  = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               hsyncN,
  input logic               varEn,
  input logic               dotEn,
  input logic [RATIO_W-1:0] divRatio
);

  logic [RATIO_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (rst || dotEn) gapCnt <= '0;
    else              gapCnt <= gapCnt + RATIO_W'(1);
  end

  // R3: pulse lands exactly when the current ratio has elapsed
  p_pulse_on_time_r3: assert property (@(posedge clk) disable iff (rst)
    dotEn |-> (int'(gapCnt) == int'(divRatio) - 1));

  // R3: no pulse before the dot is complete
  p_no_early_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    !dotEn |-> (int'(gapCnt) < int'(divRatio) - 1));

  // R3: single-cycle pulse
  p_single_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    dotEn |=> !dotEn);

  // R7: ratio only moves right after a dot end
  p_ratio_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    !dotEn |=> $stable(divRatio));

  // R2: ratio is always one of the two legal values
  p_legal_ratio_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(divRatio) == FAST_DIV) || (int'(divRatio) == SLOW_DIV));

  // R8: mode off forces the fast rate for the next dot
  p_fixed_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    (dotEn && !varEn) |=> (int'(divRatio) == FAST_DIV));

  // R2: fast rate with sync released never turns slow
  p_fast_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (dotEn && hsyncN && int'(divRatio) == FAST_DIV) |=> (int'(divRatio) == FAST_DIV));

  // R5: slow rate persists while sync stays asserted and mode is on
  p_slow_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (dotEn && !hsyncN && varEn && int'(divRatio) == SLOW_DIV) |=> (int'(divRatio) == SLOW_DIV));

endmodule

bind dotclk_gen dotclk_chk #(
  .FAST_DIV(FAST_DIV),
  .SLOW_DIV(SLOW_DIV),
  .RATIO_W (RATIO_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .hsyncN  (hsyncN),
  .varEn   (varEn),
  .dotEn   (dotEn),
  .divRatio(divRatio)
);

// File: tb/tb_dotclk_gen.sv
module tb_dotclk_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsyncN = 1'b1;
  logic       varEn = 1'b1;
  logic       dotEn;
  logic [2:0] divRatio;

  always #2 clk = ~clk;

  dotclk_gen dut (
    .clk     (clk),
    .rst     (rst),
    .hsyncN  (hsyncN),
    .varEn   (varEn),
    .dotEn   (dotEn),
    .divRatio(divRatio)
  );

  typedef struct {
    int    period;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  int  periodCnt = 0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: measures each dot and compares it with the queued prediction.
  always @(negedge clk) begin
    expItem_t it;
    cyc++;
    if (rst) begin
      periodCnt = 0;
    end else begin
      periodCnt++;
      if (dotEn) begin
        if (expQ.size() > 0) begin
          it = expQ.pop_front();
          check(periodCnt == it.period, it.tag, "dot period", periodCnt, it.period);
          check(int'(divRatio) == it.period, it.tag, "ratio at dot end",
                int'(divRatio), it.period);
        end
        periodCnt = 0;
      end
    end
  end

  // Driver: sets the inputs sampled at the next dot end, queues that dot's period.
  task automatic stepDot(input bit hs, input bit ve, input int exp, input string tag);
    @(negedge clk iff dotEn);
    #1;
    hsyncN = hs;
    varEn  = ve;
    expQ.push_back('{exp, tag});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3: actual=%0d expected=%0d (pulses stopped)", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int t0;
    int t1;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(dotEn == 1'b0, "R1", "dotEn in reset", int'(dotEn), 0);
    check(int'(divRatio) == 4, "R1", "ratio in reset", int'(divRatio), 4);
    @(negedge clk);
    #1 rst = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!dotEn && n < 20);
    check(n == 3, "R1", "edges to first pulse", n, 3);

    // R2: idle fast rate
    for (int i = 0; i < 6; i++) stepDot(1'b1, 1'b1, 4, "R2");

    // R4, R5, R9: full 64-dot sync window
    stepDot(1'b0, 1'b1, 4, "R4");
    t0 = cyc;
    for (int i = 1; i < 7; i++)  stepDot(1'b0, 1'b1, 4, "R4");
    for (int i = 0; i < 57; i++) stepDot(1'b0, 1'b1, 5, "R5");
    // R6: release, exit lag then fast
    stepDot(1'b1, 1'b1, 5, "R6");
    t1 = cyc;
    check(t1 - t0 == 313, "R9", "64-dot window clocks", t1 - t0, 313);
    stepDot(1'b1, 1'b1, 5, "R6");
    stepDot(1'b1, 1'b1, 5, "R6");
    for (int i = 0; i < 4; i++) stepDot(1'b1, 1'b1, 4, "R6");

    // R10: short sync inside entry lag
    for (int i = 0; i < 3; i++) stepDot(1'b0, 1'b1, 4, "R10");
    for (int i = 0; i < 4; i++) stepDot(1'b1, 1'b1, 4, "R10");

    // R11: re-assert during exit lag
    for (int i = 0; i < 7; i++) stepDot(1'b0, 1'b1, 4, "R4");
    for (int i = 0; i < 3; i++) stepDot(1'b0, 1'b1, 5, "R5");
    stepDot(1'b1, 1'b1, 5, "R6");
    stepDot(1'b1, 1'b1, 5, "R6");
    for (int i = 0; i < 3; i++) stepDot(1'b0, 1'b1, 5, "R11");
    for (int i = 0; i < 3; i++) stepDot(1'b1, 1'b1, 5, "R6");
    for (int i = 0; i < 3; i++) stepDot(1'b1, 1'b1, 4, "R6");

    // R8: mode off ignores sync, then mode on mid-sync, then off while slow
    for (int i = 0; i < 5; i++) stepDot(1'b0, 1'b0, 4, "R8");
    for (int i = 0; i < 7; i++) stepDot(1'b0, 1'b1, 4, "R4");
    for (int i = 0; i < 2; i++) stepDot(1'b0, 1'b1, 5, "R5");
    stepDot(1'b0, 1'b0, 4, "R8");
    stepDot(1'b0, 1'b0, 4, "R8");
    for (int i = 0; i < 3; i++) stepDot(1'b1, 1'b1, 4, "R2");

    // Drain the last prediction, then R3 pulse width
    @(negedge clk iff dotEn);
    @(negedge clk);
    check(dotEn == 1'b0, "R3", "pulse width", int'(dotEn), 0);
    check(expQ.size() == 0, "R3", "unmatched predictions", expQ.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule